// File: doc/BRIEF.md
# Multi-frame DMA channel sequencer

This block sequences the addresses and counts of a single DMA channel. Each element moves as one read request followed by one write request toward memory, each held until the memory acknowledges it. After each acknowledge, the address on that side is updated by its own rule. Elements are counted within a frame and frames within a block. A circular-buffer mode instead treats one frame as a ring that never completes.

Software programs the channel through a small write-only register port and arms it by setting the enable bit. The channel can either run freely or wait for a synchronization event before each element. An optional auto-initialisation reloads the frame count and the base addresses when a block ends, so the channel keeps going. A single interrupt line pulses on half-buffer, full-buffer, end-of-frame or end-of-block events, depending on the selected mode.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset `rd_req_o`, `wr_req_o`, `irq_o` and `en_o` are low.
- R2: Register addresses are 0 source base, 1 destination base, 2 source index, 3 destination index, 4 elements per frame, 5 frames per block, 6 frame reload and 7 control. Control bits are: [0] enable, [2:1] source mode, [4:3] destination mode, [5] sync enable, [6] circular-buffer mode, [7] interrupt enable, [8] interrupt mode, [9] auto-init. Writing control with bit 0 set loads the counters and the running addresses from the programmed values. Each element is one read followed by one write. A request stays high with a stable address until it is acknowledged.
- R3: The address mode code is 0 hold, 1 add one, 2 subtract one, or 3 add the side's index register (two's complement, modulo 2^AW). The mode is applied to the source after each read acknowledge and to the destination after each write acknowledge. The two sides are independent.
- R4: A frame consists of as many read/write pairs as the element count.
- R5: A block consists of as many frames as the frame count. The frame counter decrements on the last read of each frame.
- R6: With auto-init set, the frame counter reloads from the frame reload register when a block ends. Both running addresses return to their bases, and the channel stays enabled.
- R7: Without auto-init, the enable bit clears when a block ends (`en_o` falls), and no further request is issued.
- R8: With sync enable set, each element starts only when `sync_i` is high while the channel is idle. Sync events while the channel is disabled have no effect.
- R9: In multi-frame operation with interrupts enabled, interrupt mode 0 pulses once per block. Interrupt mode 1 pulses at every frame end, including the last.
- R10: In circular-buffer mode, one frame forms the ring, and both addresses return to base after its last element. Interrupt mode 0 pulses on a full buffer only. Interrupt mode 1 also pulses after N>>1 elements (for N ≥ 2).
- R11: With the interrupt enable bit clear, `irq_o` never pulses.
- R12: The interrupt is a pulse one cycle wide, raised in the cycle after the write acknowledge that completes the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register select |
| reg_wdata_i | input | AW | Register write data |
| sync_i | input | 1 | Synchronization event |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | AW | Read address |
| rd_ack_i | input | 1 | Read acknowledge |
| wr_req_o | output | 1 | Write request |
| wr_addr_o | output | AW | Write address |
| wr_ack_i | input | 1 | Write acknowledge |
| irq_o | output | 1 | Interrupt pulse |
| en_o | output | 1 | Channel enable state |

## Verification
The bench builds the block with AW=12, EW=8 and FW=4. The narrow address lets a decrementing source wrap below zero within a few elements. It also makes a negative destination index (0xFFE) exercise two's-complement stepping. The 4-bit frame fields keep block lengths and auto-init reloads short enough to be driven element by element with sync pulses. Under these parameters, half-buffer, full-buffer, frame-end and block-end interrupts all occur within a few dozen transfers.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {
    AM_HOLD = 2'd0,
    AM_INC  = 2'd1,
    AM_DEC  = 2'd2,
    AM_IDX  = 2'd3
  } addr_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } xfer_st_e;

  // bit 0 = en ... bit 9 = autoinit
  typedef struct packed {
    logic       autoinit;
    logic       imod;
    logic       irq_en;
    logic       ring;
    logic       sync_en;
    addr_mode_e dst_mode;
    addr_mode_e src_mode;
    logic       en;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

  localparam logic [2:0] RA_SRC_BASE = 3'd0;
  localparam logic [2:0] RA_DST_BASE = 3'd1;
  localparam logic [2:0] RA_SRC_IDX  = 3'd2;
  localparam logic [2:0] RA_DST_IDX  = 3'd3;
  localparam logic [2:0] RA_ELEM     = 3'd4;
  localparam logic [2:0] RA_FRAME    = 3'd5;
  localparam logic [2:0] RA_FRLD     = 3'd6;
  localparam logic [2:0] RA_CTL      = 3'd7;
endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step
  import dma_seq_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  addr_mode_e    mode_i,
  input  logic [AW-1:0] index_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] next_addr;

  always_comb begin
    unique case (mode_i)
      AM_INC:  next_addr = addr_o + AW'(1);
      AM_DEC:  next_addr = addr_o - AW'(1);
      AM_IDX:  next_addr = addr_o + index_i;
      default: next_addr = addr_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_o <= '0;
    else if (load_i) addr_o <= base_i;
    else if (step_i) addr_o <= next_addr;
  end

  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && (!step_i || mode_i == AM_HOLD)) |=> $stable(addr_o)); // R3
  AST_ADDR_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && step_i && mode_i == AM_INC) |=> addr_o == $past(addr_o) + AW'(1)); // R3
endmodule

// File: rtl/dma_xfer_cnt.sv
module dma_xfer_cnt #(
  parameter int EW = 16,
  parameter int FW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          arm_i,
  input  logic [EW-1:0] elem_len_i,
  input  logic [FW-1:0] frame_len_i,
  input  logic [FW-1:0] frame_rld_i,
  input  logic          autoinit_i,
  input  logic          ring_i,
  input  logic          rd_done_i,
  input  logic          wr_done_i,
  output logic          last_elem_o,
  output logic          half_o,
  output logic          block_end_o
);
  logic [EW-1:0] elem_left_q;
  logic [FW-1:0] frame_left_q;
  logic          is_last, hits_half, last_frame;

  assign is_last    = elem_left_q <= EW'(1);
  assign hits_half  = (elem_len_i >= EW'(2)) &&
                      (elem_left_q - EW'(1) == elem_len_i - (elem_len_i >> 1));
  assign last_frame = frame_left_q <= FW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      elem_left_q  <= '0;
      frame_left_q <= '0;
      last_elem_o  <= 1'b0;
      half_o       <= 1'b0;
      block_end_o  <= 1'b0;
    end else if (arm_i) begin
      elem_left_q  <= elem_len_i;
      frame_left_q <= frame_len_i;
      last_elem_o  <= 1'b0;
      half_o       <= 1'b0;
      block_end_o  <= 1'b0;
    end else if (rd_done_i) begin
      elem_left_q <= is_last ? elem_len_i : elem_left_q - EW'(1);
      if (is_last && !ring_i && frame_left_q != '0)
        frame_left_q <= frame_left_q - FW'(1);
      last_elem_o <= is_last;
      half_o      <= hits_half;
      block_end_o <= is_last && !ring_i && last_frame;
    end else if (wr_done_i && block_end_o && autoinit_i) begin
      frame_left_q <= frame_rld_i;
    end
  end

  AST_BLOCK_IS_FRAME_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_end_o |-> last_elem_o); // R5
endmodule

// File: rtl/dma_irq_sel.sv
module dma_irq_sel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ev_i,
  input  logic irq_en_i,
  input  logic imod_i,
  input  logic ring_i,
  input  logic half_i,
  input  logic last_elem_i,
  input  logic block_end_i,
  output logic irq_o
);
  logic fire;

  always_comb begin
    if (!irq_en_i || !ev_i) fire = 1'b0;
    else if (ring_i)        fire = last_elem_i || (imod_i && half_i);
    else                    fire = imod_i ? last_elem_i : block_end_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= fire;
  end

  AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o || $past(ev_i)); // R12
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(irq_en_i)); // R11
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int EW = 16,
  parameter int FW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [2:0]    reg_addr_i,
  input  logic [AW-1:0] reg_wdata_i,
  input  logic          sync_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic          rd_ack_i,
  output logic          wr_req_o,
  output logic [AW-1:0] wr_addr_o,
  input  logic          wr_ack_i,
  output logic          irq_o,
  output logic          en_o
);
  localparam int NSIDE = 2;

  ctl_t          ctl_q;
  xfer_st_e      st_q;
  logic [AW-1:0] base_q [NSIDE];
  logic [AW-1:0] idx_q  [NSIDE];
  logic [AW-1:0] addr   [NSIDE];
  logic [EW-1:0] elem_len_q;
  logic [FW-1:0] frame_len_q, frame_rld_q;
  logic          rd_done, wr_done, arm, rewind, stop;
  logic          last_elem, half, block_end;
  addr_mode_e    mode   [NSIDE];
  logic          step   [NSIDE];

  assign rd_done = (st_q == ST_RD) && rd_ack_i;
  assign wr_done = (st_q == ST_WR) && wr_ack_i;
  assign arm     = reg_we_i && reg_addr_i == RA_CTL && reg_wdata_i[0];
  assign rewind  = wr_done && ((block_end && ctl_q.autoinit) || (ctl_q.ring && last_elem));
  assign stop    = wr_done && block_end && !ctl_q.autoinit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q       <= '0;
      base_q      <= '{default: '0};
      idx_q       <= '{default: '0};
      elem_len_q  <= '0;
      frame_len_q <= '0;
      frame_rld_q <= '0;
    end else if (reg_we_i) begin
      unique case (reg_addr_i)
        RA_SRC_BASE: base_q[0]   <= reg_wdata_i;
        RA_DST_BASE: base_q[1]   <= reg_wdata_i;
        RA_SRC_IDX:  idx_q[0]    <= reg_wdata_i;
        RA_DST_IDX:  idx_q[1]    <= reg_wdata_i;
        RA_ELEM:     elem_len_q  <= reg_wdata_i[EW-1:0];
        RA_FRAME:    frame_len_q <= reg_wdata_i[FW-1:0];
        RA_FRLD:     frame_rld_q <= reg_wdata_i[FW-1:0];
        default:     ctl_q       <= ctl_t'(reg_wdata_i[CTL_W-1:0]);
      endcase
    end else if (stop) begin
      ctl_q.en <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else begin
      unique case (st_q)
        ST_IDLE: if (ctl_q.en && (!ctl_q.sync_en || sync_i)) st_q <= ST_RD;
        ST_RD:   if (rd_ack_i) st_q <= ST_WR;
        ST_WR:   if (wr_ack_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign mode[0] = ctl_q.src_mode;
  assign mode[1] = ctl_q.dst_mode;
  assign step[0] = rd_done;
  assign step[1] = wr_done;

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    dma_addr_step #(.AW(AW)) u_step (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (arm || rewind),
      .base_i  (base_q[s]),
      .mode_i  (mode[s]),
      .index_i (idx_q[s]),
      .step_i  (step[s]),
      .addr_o  (addr[s])
    );
  end

  dma_xfer_cnt #(.EW(EW), .FW(FW)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .arm_i       (arm),
    .elem_len_i  (elem_len_q),
    .frame_len_i (frame_len_q),
    .frame_rld_i (frame_rld_q),
    .autoinit_i  (ctl_q.autoinit),
    .ring_i      (ctl_q.ring),
    .rd_done_i   (rd_done),
    .wr_done_i   (wr_done),
    .last_elem_o (last_elem),
    .half_o      (half),
    .block_end_o (block_end)
  );

  dma_irq_sel u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ev_i        (wr_done),
    .irq_en_i    (ctl_q.irq_en),
    .imod_i      (ctl_q.imod),
    .ring_i      (ctl_q.ring),
    .half_i      (half),
    .last_elem_i (last_elem),
    .block_end_i (block_end),
    .irq_o       (irq_o)
  );

  assign rd_req_o  = st_q == ST_RD;
  assign wr_req_o  = st_q == ST_WR;
  assign rd_addr_o = addr[0];
  assign wr_addr_o = addr[1];
  assign en_o      = ctl_q.en;

  AST_RD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_ack_i && !reg_we_i) |=> rd_req_o && $stable(rd_addr_o)); // R2
  AST_WR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o && !wr_ack_i && !reg_we_i) |=> wr_req_o && $stable(wr_addr_o)); // R2
  AST_STOP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop && !reg_we_i) |=> !en_o && !rd_req_o && !wr_req_o); // R7
endmodule

// File: tb/dma_chan_seq_test.sv
module dma_chan_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int EW = 8;
  localparam int FW = 4;
  localparam logic [AW-1:0] AMASK = '1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [AW-1:0] reg_wdata = '0;
  logic sync = 1'b0, rd_ack = 1'b0, wr_ack = 1'b0;
  logic rd_req, wr_req, irq, en;
  logic [AW-1:0] rd_addr, wr_addr;

  int checks = 0, errors = 0;
  int rd_n = 0, wr_n = 0, irq_n = 0, stall = 0;
  logic irq_prev = 1'b0;
  logic [AW-1:0] rd_log [64];
  logic [AW-1:0] wr_log [64];
  bit done = 0;

  dma_chan_seq #(.AW(AW), .EW(EW), .FW(FW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .sync_i(sync),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_ack_i(rd_ack),
    .wr_req_o(wr_req), .wr_addr_o(wr_addr), .wr_ack_i(wr_ack),
    .irq_o(irq), .en_o(en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // memory responder and interrupt monitor
  initial forever begin
    @(negedge clk);
    if (rd_req && stall > 0) begin
      stall--;
      rd_ack = 1'b0;
    end else begin
      if (rd_req && !rd_ack && rd_n < 64) begin rd_log[rd_n] = rd_addr; rd_n++; end
      rd_ack = rd_req;
    end
    if (wr_req && !wr_ack && wr_n < 64) begin wr_log[wr_n] = wr_addr; wr_n++; end
    wr_ack = wr_req;
    if (irq) begin
      irq_n++;
      if (irq_prev) begin
        errors++;
        $display("FAIL R12: irq high two cycles, actual 1 expected 0");
      end
    end
    irq_prev = irq;
  end

  task automatic check_eq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [2:0] a, logic [AW-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  function automatic logic [AW-1:0] ctl(bit e, logic [1:0] sm, logic [1:0] dm, bit sy,
                                        bit ring, bit ie, bit im, bit ai);
    return AW'({ai, im, ie, ring, sy, dm, sm, e});
  endfunction

  task automatic clear_logs();
    rd_n = 0; wr_n = 0; irq_n = 0;
  endtask

  task automatic setup(logic [AW-1:0] sb, logic [AW-1:0] db, logic [AW-1:0] si,
                       logic [AW-1:0] di, int ne, int nf, int rld);
    wr_reg(3'd0, sb); wr_reg(3'd1, db); wr_reg(3'd2, si); wr_reg(3'd3, di);
    wr_reg(3'd4, AW'(ne)); wr_reg(3'd5, AW'(nf)); wr_reg(3'd6, AW'(rld));
  endtask

  task automatic wait_off();
    for (int i = 0; i < 500 && en; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_sync();
    @(negedge clk); sync = 1'b1;
    @(negedge clk); sync = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    check_eq("R1 rd_req", int'(rd_req), 0);
    check_eq("R1 wr_req", int'(wr_req), 0);
    check_eq("R1 irq", int'(irq), 0);
    check_eq("R1 en", int'(en), 0);
  endtask

  // R3 R4 R5 R9 R7: inc source, indexed destination, imod 1
  task automatic t_multi_frame();
    int bad = 0;
    clear_logs();
    setup(12'h100, 12'h200, 12'h000, 12'h003, 3, 2, 0);
    wr_reg(3'd7, ctl(1, 2'd1, 2'd3, 0, 0, 1, 1, 0));
    wait_off();
    check_eq("R4 R5 read count", rd_n, 6);
    check_eq("R4 write count", wr_n, 6);
    for (int i = 0; i < 6; i++) begin
      if (rd_log[i] != ((12'h100 + i) & AMASK)) bad++;
      if (wr_log[i] != ((12'h200 + 3 * i) & AMASK)) bad++;
    end
    check_eq("R3 address sequence mismatches", bad, 0);
    check_eq("R9 imod1 frame irqs", irq_n, 2);
    check_eq("R7 en after block", int'(en), 0);
  endtask

  // R2 handshake hold, R3 decrement wrap and hold, R9 imod 0
  task automatic t_dec_hold();
    int bad = 0;
    logic [AW-1:0] a0;
    clear_logs();
    setup(12'h001, 12'h050, 12'h000, 12'h000, 2, 3, 0);
    stall = 3;
    wr_reg(3'd7, ctl(1, 2'd2, 2'd0, 0, 0, 1, 0, 0));
    while (!rd_req) @(negedge clk);
    a0 = rd_addr;
    repeat (2) begin
      @(negedge clk);
      check_eq("R2 rd_req held", int'(rd_req), 1);
      check_eq("R2 rd_addr stable", int'(rd_addr), int'(a0));
    end
    wait_off();
    check_eq("R5 read count", rd_n, 6);
    for (int i = 0; i < 6; i++) begin
      if (rd_log[i] != ((12'h001 - i) & AMASK)) bad++;
      if (wr_log[i] != 12'h050) bad++;
    end
    check_eq("R3 dec/hold mismatches", bad, 0);
    check_eq("R9 imod0 block irq", irq_n, 1);
  endtask

  task automatic t_no_irq();
    clear_logs();
    setup(12'h000, 12'h010, 12'h000, 12'h000, 2, 2, 0);
    wr_reg(3'd7, ctl(1, 2'd1, 2'd1, 0, 0, 0, 1, 0));
    wait_off();
    check_eq("R11 reads", rd_n, 4);
    check_eq("R11 no irq", irq_n, 0);
  endtask

  task automatic t_sync();
    clear_logs();
    setup(12'h300, 12'h400, 12'h000, 12'h000, 2, 1, 0);
    wr_reg(3'd7, ctl(1, 2'd1, 2'd1, 1, 0, 1, 1, 0));
    repeat (10) @(negedge clk);
    check_eq("R8 no start without sync", rd_n, 0);
    pulse_sync();
    check_eq("R8 one element per sync", rd_n, 1);
    check_eq("R8 write follows", wr_n, 1);
    pulse_sync();
    check_eq("R8 second element", rd_n, 2);
    check_eq("R7 en cleared", int'(en), 0);
    check_eq("R9 single frame irq", irq_n, 1);
    pulse_sync();
    check_eq("R7 R8 sync ignored when off", rd_n, 2);
  endtask

  task automatic t_autoinit();
    int bad = 0;
    logic [AW-1:0] er [5] = '{12'h010, 12'h011, 12'h010, 12'h011, 12'h012};
    logic [AW-1:0] ew [5] = '{12'h020, 12'h01E, 12'h020, 12'h01E, 12'h01C};
    clear_logs();
    setup(12'h010, 12'h020, 12'h000, 12'hFFE, 1, 2, 3);
    wr_reg(3'd7, ctl(1, 2'd1, 2'd3, 1, 0, 1, 1, 1));
    repeat (5) pulse_sync();
    check_eq("R6 reads", rd_n, 5);
    for (int i = 0; i < 5; i++) begin
      if (rd_log[i] != er[i]) bad++;
      if (wr_log[i] != ew[i]) bad++;
    end
    check_eq("R6 reload address mismatches", bad, 0);
    check_eq("R6 still enabled", int'(en), 1);
    check_eq("R6 R9 irqs", irq_n, 5);
    wr_reg(3'd7, ctl(0, 2'd0, 2'd0, 0, 0, 0, 0, 0));
  endtask

  task automatic t_ring();
    int bad = 0;
    clear_logs();
    setup(12'h500, 12'h600, 12'h000, 12'h000, 4, 1, 0);
    wr_reg(3'd7, ctl(1, 2'd1, 2'd2, 1, 1, 1, 1, 0));
    pulse_sync(); pulse_sync();
    check_eq("R10 half-buffer irq", irq_n, 1);
    repeat (6) pulse_sync();
    check_eq("R10 reads", rd_n, 8);
    for (int i = 0; i < 8; i++) begin
      if (rd_log[i] != ((12'h500 + (i % 4)) & AMASK)) bad++;
      if (wr_log[i] != ((12'h600 - (i % 4)) & AMASK)) bad++;
    end
    check_eq("R10 ring address mismatches", bad, 0);
    check_eq("R10 imod1 irqs", irq_n, 4);
    check_eq("R10 ring stays enabled", int'(en), 1);
    clear_logs();
    wr_reg(3'd7, ctl(1, 2'd1, 2'd2, 1, 1, 1, 0, 0));
    repeat (4) pulse_sync();
    check_eq("R10 imod0 full only", irq_n, 1);
    wr_reg(3'd7, ctl(0, 2'd0, 2'd0, 0, 0, 0, 0, 0));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_multi_frame();
    t_dec_hold();
    t_no_irq();
    t_sync();
    t_autoinit();
    t_ring();
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule